// File: doc/BRIEF.md
# Host Register Port with Atomic AND/OR Access

This block is the host-facing register port of a network adapter's attachment control area. Each host bus cycle presents a 9-bit offset and a data byte on a single strobe. The offset is split into three fields: a register index, an operation code and an area selector. The operation code lets the host write a register, AND a mask into it, OR bits into it, or read it, all in one bus cycle. Clearing or setting single bits therefore needs no read-modify-write sequence, and it cannot race with the hardware.

The block holds a shared-RAM base relocation register, a read-only RAM-size report and the host interrupt status/control register. Hardware event inputs set status bits, and an AND access clears them. The block drives an interrupt request line, or a channel-check line in its place, from the enabled status. Accesses to the two identification areas return constant bytes. Accesses that are not allowed raise an access status bit.

Top module: `hostRegPort`

## Requirements
- R1: Offset bits [4:0] select the register, bits [6:5] select the operation (00 write, 01 AND, 10 OR, 11 read), and bits [8:7] select the area (00 control, 01 reserved, 10 identification A, 11 identification B).
- R2: Control register 0 holds the shared-RAM base bits 19..13 in its bits [7:1]. Write, AND and OR act on those bits, bit 0 always reads 0, and the register does not change without an access to it.
- R3: Control register 1 reads the 2-bit RAM-size strap in bits [3:2] (00 8 KB, 01 16 KB, 10 32 KB, 11 64 KB) with every other bit 0. Write, AND and OR leave its read value unchanged.
- R4: Control register 8 bit 7 (output select) and bit 6 (interrupt enable) follow write, AND and OR.
- R5: Register 8 status bits are bit 4 (timer), bit 3 (internal error) and bit 2 (access). Their event inputs set them. Only an AND access to register 8 clears them, and only where the mask bit is 0. An event that arrives in the same cycle as a clear leaves its bit set.
- R6: The access bit is set by these accesses: a write, AND or OR to a control register other than 0, 1 or 8; a write, AND or OR to either identification area; any access to the reserved area. A read of the reserved area returns 0xFF.
- R7: The interrupt is active when bit 6 is 1 and any of bits 4, 3 or 2 is 1. When it is active, bit 7 = 1 drives irqOut and bit 7 = 0 drives chckOut. Both outputs are low when the interrupt is not active.
- R8: Read data appears on rdData one clock after the read strobe, with rdValid high for that one cycle. rdData keeps its value across accesses that are not reads.
- R9: Identification area A at index i returns byte (i mod ID_BYTES) of ID_VALUE, byte 0 being the least significant. Area B at index i returns (i[0] ? 0xAA : 0x55) XOR i. Reads of either area do not set the access bit.
- R10: Register 8 bit 0 reads the adapterAlt strap (0 primary, 1 alternate). Bits 5 and 1 read 0. Writes do not affect any of these bits.
- R11: After reset, the relocation base, bits 7 and 6, and all status bits are 0, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accStrobe | input | 1 | One host bus cycle this clock |
| accOffset | input | 9 | Area, operation and register fields |
| accWrData | input | 8 | Data or mask byte |
| ramSizeStrap | input | 2 | RAM size code reported in register 1 |
| adapterAlt | input | 1 | Primary (0) or alternate (1) adapter strap |
| evtTimer | input | 1 | Timer expiry event |
| evtError | input | 1 | Internal error event |
| rdData | output | 8 | Read data, registered |
| rdValid | output | 1 | rdData updated this cycle |
| irqOut | output | 1 | Interrupt request |
| chckOut | output | 1 | Channel-check line |

## Verification
A hardware event and a host AND clear can target the same status bit in the same cycle. The bench drives evtTimer or evtError in the very cycle of an AND access whose mask clears that bit. It then reads register 8 and expects the bit to still be set. A read of register 8 in the same cycle as an event is also exercised: the read must return the value held before the event, and the interrupt outputs must reflect the event from the next cycle on.

// File: rtl/hrpPkg.sv
package hrpPkg;
  localparam int OFS_W    = 9;
  localparam int IDX_W    = 5;
  localparam int DATA_W   = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_AND   = 2'b01,
    OP_OR    = 2'b10,
    OP_READ  = 2'b11
  } hrpOpE;

  typedef enum logic [1:0] {
    AREA_CTRL = 2'b00,
    AREA_RSVD = 2'b01,
    AREA_IDA  = 2'b10,
    AREA_IDB  = 2'b11
  } hrpAreaE;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic                relocUpd;
    logic                intStatUpd;
    logic                rdLoad;
    logic                accessFault;
    hrpOpE               op;
    hrpAreaE             area;
    logic [IDX_W-1:0]    regIdx;
    logic [DATA_W-1:0]   data;
  } hrpStrobesT;
endpackage

// File: rtl/hrpCtrl.sv
module hrpCtrl
  import hrpPkg::*;
#(
  parameter int REG_RELOC = 0,
  parameter int REG_SIZE  = 1,
  parameter int REG_INT   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accStrobe,
  input  logic [OFS_W-1:0]   accOffset,
  input  logic [DATA_W-1:0]  accWrData,
  output hrpStrobesT         strb,
  output logic               rdValid
);
  localparam int OP_LSB   = IDX_W;
  localparam int AREA_LSB = IDX_W + 2;

  hrpOpE            opDec;
  hrpAreaE          areaDec;
  logic [IDX_W-1:0] idxDec;
  logic             isRead;
  logic             isCtrl;
  logic             knownReg;

  always_comb begin
    opDec    = hrpOpE'(accOffset[OP_LSB +: 2]);
    areaDec  = hrpAreaE'(accOffset[AREA_LSB +: 2]);
    idxDec   = accOffset[IDX_W-1:0];
    isRead   = (opDec == OP_READ);
    isCtrl   = (areaDec == AREA_CTRL);
    knownReg = (idxDec == IDX_W'(REG_RELOC)) ||
               (idxDec == IDX_W'(REG_SIZE))  ||
               (idxDec == IDX_W'(REG_INT));
  end

  always_comb begin
    strb.op          = opDec;
    strb.area        = areaDec;
    strb.regIdx      = idxDec;
    strb.data        = accWrData;
    strb.relocUpd    = accStrobe && isCtrl && !isRead && (idxDec == IDX_W'(REG_RELOC));
    strb.intStatUpd  = accStrobe && isCtrl && !isRead && (idxDec == IDX_W'(REG_INT));
    strb.rdLoad      = accStrobe && isRead;
    strb.accessFault = accStrobe && (
                         (areaDec == AREA_RSVD) ||
                         (!isCtrl && !isRead) ||
                         (isCtrl && !knownReg && !isRead));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strb.rdLoad;
  end

  AST_ONE_UPDATE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.relocUpd && strb.accessFault) && !(strb.intStatUpd && strb.accessFault)); // R6
endmodule

// File: rtl/hrpData.sv
module hrpData
  import hrpPkg::*;
#(
  parameter int          REG_RELOC = 0,
  parameter int          REG_SIZE  = 1,
  parameter int          REG_INT   = 8,
  parameter int          ID_BYTES  = 6,
  parameter logic [47:0] ID_VALUE  = 48'h3C5A_17E2_9BD4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hrpStrobesT        strb,
  input  logic [1:0]        ramSizeStrap,
  input  logic              adapterAlt,
  input  logic              evtTimer,
  input  logic              evtError,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              chckOut
);
  localparam int BASE_W = DATA_W - 1;
  localparam int ST_W   = 3;

  logic [BASE_W-1:0] relocBase;
  logic              ctlSel;
  logic              ctlEn;
  logic [ST_W-1:0]   stBits;   // {timer, error, access}
  logic [ST_W-1:0]   stMask;
  logic [ST_W-1:0]   stEvents;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] idByteA;
  logic [DATA_W-1:0] idByteB;
  logic [DATA_W-1:0] idTable [ID_BYTES];
  logic              irqActive;
  logic              unusedDataBit;

  assign unusedDataBit = strb.data[0];

  genvar g;
  generate
    for (g = 0; g < ID_BYTES; g++) begin : gIdBytes
      assign idTable[g] = ID_VALUE[8*g +: 8];
    end
  endgenerate

  always_comb begin
    idByteA = '0;
    for (int k = 0; k < ID_BYTES; k++)
      if ((int'(strb.regIdx) % ID_BYTES) == k) idByteA = idTable[k];
    idByteB = (strb.regIdx[0] ? 8'hAA : 8'h55) ^ {3'b000, strb.regIdx};
  end

  always_comb begin
    rdMux = '0;
    unique case (strb.area)
      AREA_CTRL: begin
        if (strb.regIdx == IDX_W'(REG_RELOC))
          rdMux = {relocBase, 1'b0};
        else if (strb.regIdx == IDX_W'(REG_SIZE))
          rdMux = {4'b0000, ramSizeStrap, 2'b00};
        else if (strb.regIdx == IDX_W'(REG_INT))
          rdMux = {ctlSel, ctlEn, 1'b0, stBits, 1'b0, adapterAlt};
        else
          rdMux = '0;
      end
      AREA_RSVD: rdMux = 8'hFF;
      AREA_IDA:  rdMux = idByteA;
      AREA_IDB:  rdMux = idByteB;
      default:   rdMux = '0;
    endcase
  end

  always_comb begin
    stMask   = (strb.intStatUpd && strb.op == OP_AND) ? strb.data[4:2] : {ST_W{1'b1}};
    stEvents = {evtTimer, evtError, strb.accessFault};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relocBase <= '0;
      ctlSel    <= 1'b0;
      ctlEn     <= 1'b0;
      stBits    <= '0;
      rdData    <= '0;
    end else begin
      if (strb.relocUpd) begin
        unique case (strb.op)
          OP_WRITE: relocBase <= strb.data[7:1];
          OP_AND:   relocBase <= relocBase & strb.data[7:1];
          OP_OR:    relocBase <= relocBase | strb.data[7:1];
          default:  relocBase <= relocBase;
        endcase
      end
      if (strb.intStatUpd) begin
        unique case (strb.op)
          OP_WRITE: {ctlSel, ctlEn} <= strb.data[7:6];
          OP_AND:   {ctlSel, ctlEn} <= {ctlSel, ctlEn} & strb.data[7:6];
          OP_OR:    {ctlSel, ctlEn} <= {ctlSel, ctlEn} | strb.data[7:6];
          default:  {ctlSel, ctlEn} <= {ctlSel, ctlEn};
        endcase
      end
      stBits <= (stBits & stMask) | stEvents;
      if (strb.rdLoad) rdData <= rdMux;
    end
  end

  assign irqActive = ctlEn && (|stBits);
  assign irqOut    = irqActive && ctlSel;
  assign chckOut   = irqActive && !ctlSel;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtTimer |=> stBits[2]); // R5
  AST_ERROR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtError |=> stBits[1]); // R5
  AST_ACCESS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.accessFault |=> stBits[0]); // R6
  AST_CLEAR_ONLY_BY_AND: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stBits[1]) |-> $past(strb.intStatUpd && strb.op == OP_AND)); // R5
  AST_RELOC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.relocUpd |=> $stable(relocBase)); // R2
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hrpPkg::*;
#(
  parameter int          REG_RELOC = 0,
  parameter int          REG_SIZE  = 1,
  parameter int          REG_INT   = 8,
  parameter int          ID_BYTES  = 6,
  parameter logic [47:0] ID_VALUE  = 48'h3C5A_17E2_9BD4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accStrobe,
  input  logic [8:0]  accOffset,
  input  logic [7:0]  accWrData,
  input  logic [1:0]  ramSizeStrap,
  input  logic        adapterAlt,
  input  logic        evtTimer,
  input  logic        evtError,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        irqOut,
  output logic        chckOut
);
  hrpStrobesT strb;

  hrpCtrl #(
    .REG_RELOC(REG_RELOC), .REG_SIZE(REG_SIZE), .REG_INT(REG_INT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .accOffset(accOffset),
    .accWrData(accWrData), .strb(strb), .rdValid(rdValid)
  );

  hrpData #(
    .REG_RELOC(REG_RELOC), .REG_SIZE(REG_SIZE), .REG_INT(REG_INT),
    .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .ramSizeStrap(ramSizeStrap),
    .adapterAlt(adapterAlt), .evtTimer(evtTimer), .evtError(evtError),
    .rdData(rdData), .irqOut(irqOut), .chckOut(chckOut)
  );

  AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(accStrobe && accOffset[6:5] == 2'b11)); // R8
  AST_RSVD_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(accOffset[8:7] == 2'b01)) |-> rdData == 8'hFF); // R6
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> !chckOut); // R7
endmodule

// File: tb/hostRegPort_bench.sv
module hostRegPort_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ID_N = 6;
  localparam logic [47:0] ID_VAL = 48'hA1B2_C3D4_E5F6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accStrobe = 1'b0;
  logic [8:0] accOffset = '0;
  logic [7:0] accWrData = '0;
  logic [1:0] ramSizeStrap = 2'b10;
  logic       adapterAlt = 1'b0;
  logic       evtTimer = 1'b0;
  logic       evtError = 1'b0;
  logic [7:0] rdData;
  logic       rdValid, irqOut, chckOut;

  int checks = 0;
  int errors = 0;

  logic [6:0] relocM = '0;
  logic [1:0] ctlM = '0;   // {sel, en}
  logic [2:0] statM = '0;  // {timer, error, access}

  hostRegPort #(.ID_BYTES(ID_N), .ID_VALUE(ID_VAL)) u_hostRegPort (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .accOffset(accOffset),
    .accWrData(accWrData), .ramSizeStrap(ramSizeStrap), .adapterAlt(adapterAlt),
    .evtTimer(evtTimer), .evtError(evtError), .rdData(rdData), .rdValid(rdValid),
    .irqOut(irqOut), .chckOut(chckOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] area, input logic [4:0] idx);
    logic [7:0] v;
    v = 8'h00;
    case (area)
      2'd0: begin
        if (idx == 5'd0)      v = {relocM, 1'b0};
        else if (idx == 5'd1) v = {4'b0000, ramSizeStrap, 2'b00};
        else if (idx == 5'd8) v = {ctlM, 1'b0, statM, 1'b0, adapterAlt};
      end
      2'd1: v = 8'hFF;
      2'd2: v = ID_VAL[8*(int'(idx) % ID_N) +: 8];
      default: v = (idx[0] ? 8'hAA : 8'h55) ^ {3'b000, idx};
    endcase
    return v;
  endfunction

  task automatic doAcc(input logic [1:0] area, input logic [1:0] op, input logic [4:0] idx,
                       input logic [7:0] d, input logic eT, input logic eE, input string req);
    logic [7:0] expRd;
    logic illegal;
    logic [2:0] mask;
    logic act;
    expRd = expRead(area, idx);
    illegal = (area == 2'd1) || (area[1] && op != 2'd3) ||
              (area == 2'd0 && idx != 5'd0 && idx != 5'd1 && idx != 5'd8 && op != 2'd3);
    @(negedge clk);
    accStrobe = 1'b1; accOffset = {area, op, idx}; accWrData = d;
    evtTimer = eT; evtError = eE;
    @(negedge clk);
    accStrobe = 1'b0; evtTimer = 1'b0; evtError = 1'b0;
    mask = 3'b111;
    if (area == 2'd0 && op != 2'd3) begin
      if (idx == 5'd0) begin
        if (op == 2'd0) relocM = d[7:1];
        else if (op == 2'd1) relocM = relocM & d[7:1];
        else relocM = relocM | d[7:1];
      end else if (idx == 5'd8) begin
        if (op == 2'd0) ctlM = d[7:6];
        else if (op == 2'd1) begin ctlM = ctlM & d[7:6]; mask = d[4:2]; end
        else ctlM = ctlM | d[7:6];
      end
    end
    statM = (statM & mask) | {eT, eE, illegal};
    if (op == 2'd3) chk({req, " rdData"}, rdData, expRd);
    chk({req, " rdValid R8"}, {7'b0, rdValid}, {7'b0, op == 2'd3});
    act = ctlM[0] && (|statM);
    chk("R7 irqOut", {7'b0, irqOut}, {7'b0, act && ctlM[1]});
    chk("R7 chckOut", {7'b0, chckOut}, {7'b0, act && !ctlM[1]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk("R11 irqOut", {7'b0, irqOut}, 8'h00);
    chk("R11 chckOut", {7'b0, chckOut}, 8'h00);
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R11 status");
    doAcc(2'd0, 2'd3, 5'd0, 8'h00, 0, 0, "R11 reloc");
    // R1 R2 relocation under every operation code
    for (int p = 0; p < 16; p++)
      for (int op = 0; op < 3; op++) begin
        doAcc(2'd0, 2'(op), 5'd0, 8'((p * 37) ^ (op * 91) ^ 8'h5C), 0, 0, "R2 update");
        doAcc(2'd0, 2'd3, 5'd0, 8'h00, 0, 0, "R1 R2 readback");
      end
    // R3 size strap ignores writes
    for (int s = 0; s < 4; s++) begin
      ramSizeStrap = 2'(s);
      doAcc(2'd0, 2'd0, 5'd1, 8'hFF, 0, 0, "R3 write");
      doAcc(2'd0, 2'd2, 5'd1, 8'hFF, 0, 0, "R3 or");
      doAcc(2'd0, 2'd1, 5'd1, 8'h00, 0, 0, "R3 and");
      doAcc(2'd0, 2'd3, 5'd1, 8'h00, 0, 0, "R3 size");
    end
    // R10 alternate strap and reserved bits
    adapterAlt = 1'b1;
    doAcc(2'd0, 2'd0, 5'd8, 8'h23, 0, 0, "R10 write");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R10 alt");
    adapterAlt = 1'b0;
    doAcc(2'd0, 2'd2, 5'd8, 8'h23, 0, 0, "R10 or");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R10 primary");
    // R9 identification areas, no access flag
    for (int i = 0; i < 32; i++) begin
      doAcc(2'd2, 2'd3, 5'(i), 8'h00, 0, 0, "R9 area A");
      doAcc(2'd3, 2'd3, 5'(i), 8'h00, 0, 0, "R9 area B");
    end
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R9 no flag");
    // R6 reserved reads and illegal writes
    for (int i = 0; i < 32; i++) begin
      doAcc(2'd1, 2'd3, 5'(i), 8'h00, 0, 0, "R6 reserved");
      doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R6 flag");
      doAcc(2'd0, 2'd1, 5'd8, 8'hFB, 0, 0, "R6 clear");
    end
    for (int i = 2; i < 32; i++) begin
      if (i == 8) continue;
      doAcc(2'd0, 2'(i % 3), 5'(i), 8'hA5, 0, 0, "R6 bad reg");
      doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R6 flag");
      doAcc(2'd0, 2'd1, 5'd8, 8'hFB, 0, 0, "R6 clear");
    end
    doAcc(2'd2, 2'd0, 5'd3, 8'h11, 0, 0, "R6 id write");
    doAcc(2'd3, 2'd2, 5'd4, 8'h11, 0, 0, "R6 id or");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R6 flag");
    doAcc(2'd0, 2'd1, 5'd8, 8'hFB, 0, 0, "R6 clear");
    // R4 R7 output selection
    doAcc(2'd0, 2'd0, 5'd8, 8'hC0, 0, 0, "R4 enable");
    doAcc(2'd0, 2'd3, 5'd0, 8'h00, 1, 0, "R7 timer event");
    doAcc(2'd0, 2'd1, 5'd8, 8'h7F, 0, 0, "R4 clear sel");
    doAcc(2'd0, 2'd1, 5'd8, 8'hBF, 0, 0, "R4 clear en");
    doAcc(2'd0, 2'd2, 5'd8, 8'hC0, 0, 0, "R4 or set");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R4 readback");
    // R5 event and clear in the same cycle
    doAcc(2'd0, 2'd1, 5'd8, 8'hEF, 1, 0, "R5 timer vs clear");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R5 timer kept");
    doAcc(2'd0, 2'd1, 5'd8, 8'hF7, 0, 1, "R5 error vs clear");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 1, 0, "R5 read with event");
    doAcc(2'd0, 2'd1, 5'd8, 8'hE3, 0, 0, "R5 clear all");
    doAcc(2'd0, 2'd2, 5'd8, 8'h1C, 0, 0, "R5 or ignored");
    doAcc(2'd0, 2'd3, 5'd8, 8'h00, 0, 0, "R5 cleared");
    // R8 read data held across non-read accesses
    doAcc(2'd0, 2'd3, 5'd0, 8'h00, 0, 0, "R8 read");
    held = rdData;
    doAcc(2'd0, 2'd0, 5'd0, 8'h5A, 0, 0, "R8 write");
    chk("R8 held", rdData, held);
    @(negedge clk);
    chk("R8 idle", rdData, held);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule